// File: doc/BRIEF.md
# Hysteretic Threshold Gain-Switch Controller

This block watches wideband sample streams ahead of any filtering and drives one active-high level indicator per channel. An external attenuator or variable-gain stage is switched by that indicator. The indicator turns on as soon as a sample's magnitude reaches the channel's upper threshold. It turns off only after the magnitude has stayed below the lower threshold for a programmed dwell count. Any sample at or above the lower threshold during that wait cancels the countdown.

There are four channels. Each has its own pair of thresholds, its own dwell count and its own stream selector, so it can follow any of the four input streams. Each channel also produces a copy of its indicator delayed by 0 to 7 clocks. Downstream scale selection uses that copy so that it lines up with the latency of the external gain element. A single input-enable qualifies the samples of all streams.

Top module: `gain_switch_ctrl`

## Requirements
- R1: A sample's magnitude is the absolute value of the 14-bit two's-complement word. The value -8192 saturates to 8191, so every magnitude fits in 13 unsigned bits.
- R2: On a clock with `smp_valid` high, a channel whose selected magnitude is greater than or equal to its upper threshold has its `gain_ind` bit high after that edge.
- R3: While a channel's indicator is high, enabled samples with magnitude at or above the lower threshold keep it high.
- R4: With dwell value D, the indicator falls at the edge that takes the (D+1)-th consecutive enabled sample below the lower threshold. D = 0 releases the indicator on the first such sample. The indicator never falls on an enabled clock except for this release or reset.
- R5: An enabled sample at or above the lower threshold during a countdown cancels it. Release then needs a fresh run of D+1 consecutive below-lower samples.
- R6: An enabled sample at or above the upper threshold during a countdown keeps the indicator high and clears the counter. Release again needs D+1 fresh below-lower samples.
- R7: On clocks with `smp_valid` low, the indicator and the countdown do not change, whatever the sample values.
- R8: While the indicator is low, enabled samples below the upper threshold leave it low, including samples between the two thresholds.
- R9: Channel c monitors stream `cfg_sel[2c+1:2c]`. Stream s is `smp_data[14s+13:14s]`. Channel fields pack the same way: upper and lower thresholds at [13c+12:13c], dwell at [16c+15:16c], delay at [3c+2:3c].
- R10: `gain_ind_dly[c]` equals `gain_ind[c]` delayed by `cfg_delay` clocks. The delay advances on every clock, whatever `smp_valid` is. A delay of 0 gives the same value in the same cycle.
- R11: A clock edge with `rst_n` low clears every indicator, every counter and every delay stage. Both outputs read 0 after that edge.
- R12: Channels are independent. Each channel's timing depends only on its own configuration and its selected stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Qualifies the samples of all streams on this clock |
| smp_data | input | 56 | Four 14-bit two's-complement samples, stream s at [14s+13:14s] |
| cfg_sel | input | 8 | Stream selector per channel, 2 bits each |
| cfg_upper | input | 52 | Upper (assert) threshold per channel, 13 bits each |
| cfg_lower | input | 52 | Lower (release) threshold per channel, 13 bits each |
| cfg_dwell | input | 64 | Dwell count per channel, 16 bits each |
| cfg_delay | input | 12 | Delay of the indicator copy per channel, 3 bits each |
| gain_ind | output | 4 | Level indicator per channel |
| gain_ind_dly | output | 4 | Delayed indicator copy per channel |

## Verification
The bound checker looks at every cycle and every channel. It checks that an at-or-above-upper sample sets the indicator and that at-or-above-lower samples hold it. It checks that a low indicator stays low for samples under the upper threshold, and that a disabled clock freezes the indicator. It also checks that any fall follows an enabled below-lower sample, and that delays of 0 and 1 track the indicator. Reset clearing is checked there too. Some behaviour only the bench's scenarios can show: the exact count of D+1 samples before release, the restart after an interruption, the frozen countdown across disabled clocks, and the full 0-to-7 delay alignment. The bench also sweeps all 16384 sample codes against the magnitude rule.

// File: rtl/gsw_pkg.sv
// Shared types for the gain-switch controller.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package gsw_pkg;

    // Per-channel hysteresis state: indicator low, indicator held, or countdown running.
    typedef enum logic [1:0] {
        HY_IDLE  = 2'd0,
        HY_HOLD  = 2'd1,
        HY_COUNT = 2'd2
    } hyst_state_e;

endpackage

// File: rtl/gsw_magnitude.sv
// Saturating absolute value of one two's-complement sample.
// The most negative code maps to the largest positive magnitude, so the
// result always fits in SW-1 unsigned bits.
// Assumes: SW >= 2.
module gsw_magnitude #(
    parameter int SW = 14,
    localparam int MW = SW - 1
) (
    input  logic [SW-1:0] smp,
    output logic [MW-1:0] mag
);

    localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};

    logic [SW-1:0] negated;

    // Negate the sample and pick the positive form, saturating the most negative code.
    always_comb begin
        negated = (~smp) + SW'(1);
        if (!smp[SW-1]) begin
            mag = smp[MW-1:0];
        end else if (smp == MOST_NEG) begin
            mag = {MW{1'b1}};
        end else begin
            mag = negated[MW-1:0];
        end
    end

endmodule

// File: rtl/gsw_hyst_chan.sv
// Hysteresis engine for one channel.
// It raises the indicator when the magnitude reaches the upper threshold.
// It drops the indicator after dwell+1 consecutive enabled samples below
// the lower threshold. A sample at or above the lower threshold cancels
// a running countdown.
// Assumes: thresholds are static while samples are being judged, and all
// state moves only on clocks with en high.
module gsw_hyst_chan
    import gsw_pkg::*;
#(
    parameter int TW = 13,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [TW-1:0] mag,
    input  logic [TW-1:0] upper,
    input  logic [TW-1:0] lower,
    input  logic [DW-1:0] dwell,
    output logic          ind
);

    hyst_state_e   state_q, state_d;
    logic [DW-1:0] cnt_q, cnt_d;
    logic          at_upper;
    logic          below_lower;

    // Compare the magnitude against both thresholds.
    always_comb begin
        at_upper    = (mag >= upper);
        below_lower = (mag < lower);
    end

    // Next state and counter for one enabled sample.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (en) begin
            if (at_upper) begin
                state_d = HY_HOLD;
                cnt_d   = '0;
            end else begin
                unique case (state_q)
                    HY_IDLE: begin
                        state_d = HY_IDLE;
                        cnt_d   = '0;
                    end
                    HY_HOLD: begin
                        if (below_lower) begin
                            if (dwell == '0) begin
                                state_d = HY_IDLE;
                                cnt_d   = '0;
                            end else begin
                                state_d = HY_COUNT;
                                cnt_d   = dwell;
                            end
                        end
                    end
                    HY_COUNT: begin
                        if (!below_lower) begin
                            state_d = HY_HOLD;
                            cnt_d   = '0;
                        end else if (cnt_q <= DW'(1)) begin
                            state_d = HY_IDLE;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q - DW'(1);
                        end
                    end
                    default: begin
                        state_d = HY_IDLE;
                        cnt_d   = '0;
                    end
                endcase
            end
        end
    end

    // Register the state and counter, clearing both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // The indicator is high in every state except idle.
    always_comb begin
        ind = (state_q != HY_IDLE);
    end

endmodule

// File: rtl/gsw_delay_line.sv
// Selectable delay of 0 to 2**LW-1 clocks for one indicator bit.
// The shift stages advance on every clock. A select of 0 passes the input
// straight through.
// Assumes: the select is static or changes rarely; a change simply picks
// another tap.
module gsw_delay_line #(
    parameter int LW = 3,
    localparam int DEPTH = (1 << LW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [LW-1:0] sel,
    output logic          dout
);

    logic [DEPTH:1] stage_q;
    logic [DEPTH:0] taps;

    // Shift the indicator one stage per clock; reset empties the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[DEPTH-1:1], din};
        end
    end

    // Tap 0 is the undelayed input and tap k is k clocks old.
    always_comb begin
        taps = {stage_q, din};
        dout = taps[sel];
    end

endmodule

// File: rtl/gain_switch_ctrl.sv
// Top of the hysteretic gain-switch controller.
// It computes the magnitude of each input stream once, and each channel
// picks one stream. Every channel runs its own hysteresis engine and its
// own delay line for the indicator copy.
// Assumes: one input-enable qualifies all streams, and NSTR is a power of two.
module gain_switch_ctrl #(
    parameter int NSTR = 4,
    parameter int NCH  = 4,
    parameter int SW   = 14,
    parameter int DW   = 16,
    parameter int LW   = 3,
    localparam int TW   = SW - 1,
    localparam int SELW = (NSTR > 1) ? $clog2(NSTR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [NSTR*SW-1:0]   smp_data,
    input  logic [NCH*SELW-1:0]  cfg_sel,
    input  logic [NCH*TW-1:0]    cfg_upper,
    input  logic [NCH*TW-1:0]    cfg_lower,
    input  logic [NCH*DW-1:0]    cfg_dwell,
    input  logic [NCH*LW-1:0]    cfg_delay,
    output logic [NCH-1:0]       gain_ind,
    output logic [NCH-1:0]       gain_ind_dly
);

    logic [TW-1:0]     str_mag [NSTR];
    logic [NCH*TW-1:0] ch_mag;

    // One magnitude unit per input stream.
    for (genvar s = 0; s < NSTR; s++) begin : g_str
        gsw_magnitude #(.SW(SW)) u_mag (
            .smp (smp_data[s*SW +: SW]),
            .mag (str_mag[s])
        );
    end

    // One selector, hysteresis engine and delay line per channel.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SELW-1:0] sel_c;
        logic [TW-1:0]   mag_c;

        // Route the chosen stream's magnitude to this channel.
        always_comb begin
            sel_c = cfg_sel[c*SELW +: SELW];
            mag_c = '0;
            for (int s = 0; s < NSTR; s++) begin
                if (sel_c == SELW'(s)) begin
                    mag_c = str_mag[s];
                end
            end
        end

        assign ch_mag[c*TW +: TW] = mag_c;

        gsw_hyst_chan #(.TW(TW), .DW(DW)) u_hyst (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (smp_valid),
            .mag   (mag_c),
            .upper (cfg_upper[c*TW +: TW]),
            .lower (cfg_lower[c*TW +: TW]),
            .dwell (cfg_dwell[c*DW +: DW]),
            .ind   (gain_ind[c])
        );

        gsw_delay_line #(.LW(LW)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (gain_ind[c]),
            .sel   (cfg_delay[c*LW +: LW]),
            .dout  (gain_ind_dly[c])
        );
    end

endmodule

// File: rtl/gsw_checker.sv
// Cycle-by-cycle properties of the gain-switch controller, attached to the
// top by bind. It reads the top's ports and the per-channel magnitude
// that the selector logic drives.
// Assumes: synchronous active-low reset.
module gsw_checker #(
    parameter int NCH = 4,
    parameter int TW  = 13,
    parameter int LW  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [NCH*TW-1:0] ch_mag,
    input logic [NCH*TW-1:0] cfg_upper,
    input logic [NCH*TW-1:0] cfg_lower,
    input logic [NCH*LW-1:0] cfg_delay,
    input logic [NCH-1:0]    gain_ind,
    input logic [NCH-1:0]    gain_ind_dly
);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        logic [TW-1:0] m, up, lo;
        logic [LW-1:0] dl;
        assign m  = ch_mag[c*TW +: TW];
        assign up = cfg_upper[c*TW +: TW];
        assign lo = cfg_lower[c*TW +: TW];
        assign dl = cfg_delay[c*LW +: LW];

        assert_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && m >= up) |=> gain_ind[c]);

        assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (gain_ind[c] && smp_valid && m >= lo) |=> gain_ind[c]);

        assert_release_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(gain_ind[c]) && $past(rst_n)) |-> ($past(smp_valid) && ($past(m) < $past(lo))));

        assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!smp_valid) |=> $stable(gain_ind[c]));

        assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!gain_ind[c] && smp_valid && m < up) |=> !gain_ind[c]);

        assert_delay0_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (dl == '0) |-> (gain_ind_dly[c] == gain_ind[c]));

        assert_delay1_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (dl == LW'(1) && $past(dl) == LW'(1) && $past(rst_n)) |-> (gain_ind_dly[c] == $past(gain_ind[c])));
    end

    assert_reset_R11: assert property (@(posedge clk)
        (!rst_n) |=> (gain_ind == '0 && gain_ind_dly == '0));

endmodule

bind gain_switch_ctrl gsw_checker #(.NCH(NCH), .TW(TW), .LW(LW)) u_gsw_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .ch_mag       (ch_mag),
    .cfg_upper    (cfg_upper),
    .cfg_lower    (cfg_lower),
    .cfg_delay    (cfg_delay),
    .gain_ind     (gain_ind),
    .gain_ind_dly (gain_ind_dly)
);

// File: tb/gain_switch_ctrl_test.sv
module gain_switch_ctrl_test;

    localparam int NSTR = 4;
    localparam int NCH  = 4;
    localparam int SW   = 14;
    localparam int DW   = 16;
    localparam int LW   = 3;
    localparam int TW   = SW - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic [SW-1:0] sdat [NSTR];
    logic [1:0]    sel_r [NCH];
    logic [TW-1:0] up_r  [NCH];
    logic [TW-1:0] lo_r  [NCH];
    logic [DW-1:0] dw_r  [NCH];
    logic [LW-1:0] dl_r  [NCH];

    logic [NSTR*SW-1:0] smp_data;
    logic [NCH*2-1:0]   cfg_sel;
    logic [NCH*TW-1:0]  cfg_upper, cfg_lower;
    logic [NCH*DW-1:0]  cfg_dwell;
    logic [NCH*LW-1:0]  cfg_delay;
    logic [NCH-1:0]     gain_ind, gain_ind_dly;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int s = 0; s < NSTR; s++) smp_data[s*SW +: SW] = sdat[s];
        for (int c = 0; c < NCH; c++) begin
            cfg_sel[c*2 +: 2]     = sel_r[c];
            cfg_upper[c*TW +: TW] = up_r[c];
            cfg_lower[c*TW +: TW] = lo_r[c];
            cfg_dwell[c*DW +: DW] = dw_r[c];
            cfg_delay[c*LW +: LW] = dl_r[c];
        end
    end

    gain_switch_ctrl #(.NSTR(NSTR), .NCH(NCH), .SW(SW), .DW(DW), .LW(LW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .cfg_sel(cfg_sel), .cfg_upper(cfg_upper), .cfg_lower(cfg_lower),
        .cfg_dwell(cfg_dwell), .cfg_delay(cfg_delay),
        .gain_ind(gain_ind), .gain_ind_dly(gain_ind_dly)
    );

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
            report();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
    endtask

    task automatic all_streams(input logic [SW-1:0] v);
        for (int s = 0; s < NSTR; s++) sdat[s] = v;
    endtask

    task automatic feed(input logic [SW-1:0] v);
        all_streams(v);
        smp_valid = 1'b1;
        step();
    endtask

    task automatic std_cfg();
        for (int c = 0; c < NCH; c++) begin
            sel_r[c] = 2'd0; up_r[c] = 13'd1000; lo_r[c] = 13'd500;
            dw_r[c] = 16'd0; dl_r[c] = 3'd0;
        end
    endtask

    localparam logic [SW-1:0] HI   = 14'd1200;
    localparam logic [SW-1:0] NHI  = -14'sd1000;
    localparam logic [SW-1:0] LO   = -14'sd100;
    localparam logic [SW-1:0] MID  = 14'd700;
    localparam logic [SW-1:0] ATLO = -14'sd500;

    initial begin
        all_streams('0);
        std_cfg();
        @(negedge clk);
        do_reset();
        // R11 reset state
        check("R11 reset ind", int'(gain_ind), 0);
        check("R11 reset dly", int'(gain_ind_dly), 0);

        // R1 and R2: every sample code against the saturating magnitude
        for (int v = 0; v < (1 << SW); v++) begin
            int expm;
            expm = (v < 8192) ? v : ((v == 8192) ? 8191 : (16384 - v));
            std_cfg();
            lo_r[0] = 13'd0; lo_r[1] = 13'd0;
            up_r[0] = TW'(expm);
            up_r[1] = (expm < 8191) ? TW'(expm + 1) : TW'(8191);
            do_reset();
            feed(SW'(v));
            check("R1 R2 at threshold", int'(gain_ind[0]), 1);
            if (expm < 8191) check("R1 one below threshold", int'(gain_ind[1]), 0);
        end

        // R4 and R12: release after dwell+1 low samples, dwell differs per channel
        for (int d = 0; d < 5; d++) begin
            std_cfg();
            for (int c = 0; c < NCH; c++) dw_r[c] = DW'(d + c);
            do_reset();
            feed(HI);
            check("R2 assert all", int'(gain_ind), 15);
            for (int k = 1; k <= 9; k++) begin
                feed(LO);
                for (int c = 0; c < NCH; c++)
                    check("R4 R12 dwell release", int'(gain_ind[c]), (k < d + c + 1) ? 1 : 0);
            end
        end

        // R3: hold while between thresholds
        std_cfg();
        do_reset();
        feed(HI);
        for (int k = 0; k < 6; k++) begin
            feed(MID);
            check("R3 hold", int'(gain_ind[0]), 1);
        end
        feed(ATLO);
        check("R3 hold at lower", int'(gain_ind[0]), 1);

        // R5: restart by a sample exactly at lower threshold
        std_cfg();
        for (int c = 0; c < NCH; c++) dw_r[c] = 16'd3;
        do_reset();
        feed(HI);
        for (int k = 0; k < 3; k++) feed(LO);
        check("R5 before cancel", int'(gain_ind[0]), 1);
        feed(ATLO);
        check("R5 cancel", int'(gain_ind[0]), 1);
        for (int k = 0; k < 3; k++) begin
            feed(LO);
            check("R5 fresh count", int'(gain_ind[0]), 1);
        end
        feed(LO);
        check("R5 release", int'(gain_ind[0]), 0);

        // R6: upper sample during countdown
        do_reset();
        feed(HI);
        for (int k = 0; k < 3; k++) feed(LO);
        feed(NHI);
        check("R6 upper in countdown", int'(gain_ind[0]), 1);
        for (int k = 0; k < 3; k++) begin
            feed(LO);
            check("R6 fresh count", int'(gain_ind[0]), 1);
        end
        feed(LO);
        check("R6 release", int'(gain_ind[0]), 0);

        // R7: disabled clocks freeze the countdown and ignore samples
        std_cfg();
        for (int c = 0; c < NCH; c++) dw_r[c] = 16'd2;
        do_reset();
        feed(HI);
        feed(LO);
        smp_valid = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step();
            check("R7 frozen", int'(gain_ind[0]), 1);
        end
        feed(LO);
        check("R7 resume", int'(gain_ind[0]), 1);
        feed(LO);
        check("R7 release", int'(gain_ind[0]), 0);
        smp_valid = 1'b0;
        all_streams(HI);
        step();
        step();
        check("R7 ignored high", int'(gain_ind), 0);

        // R8: idle stays low below upper
        std_cfg();
        do_reset();
        feed(MID);
        check("R8 mid", int'(gain_ind), 0);
        feed(14'd999);
        check("R8 just under upper", int'(gain_ind), 0);

        // R9: each channel follows its selected stream
        for (int s = 0; s < NSTR; s++) begin
            std_cfg();
            for (int c = 0; c < NCH; c++) sel_r[c] = 2'(c);
            do_reset();
            all_streams('0);
            sdat[s] = HI;
            smp_valid = 1'b1;
            step();
            check("R9 select", int'(gain_ind), 1 << s);
        end

        // R10: delay alignment for every tap
        for (int d = 0; d < 8; d++) begin
            std_cfg();
            for (int c = 0; c < NCH; c++) dl_r[c] = 3'((d + c) % 8);
            do_reset();
            feed('0);
            feed('0);
            check("R10 idle dly", int'(gain_ind_dly), 0);
            feed(HI);
            for (int k = 0; k < 10; k++) begin
                for (int c = 0; c < NCH; c++)
                    check("R10 delay", int'(gain_ind_dly[c]), (k >= (d + c) % 8) ? 1 : 0);
                feed(HI);
            end
        end

        // R11: reset mid-countdown clears indicator and delay line
        std_cfg();
        for (int c = 0; c < NCH; c++) begin dw_r[c] = 16'd5; dl_r[c] = 3'd7; end
        do_reset();
        for (int k = 0; k < 9; k++) feed(HI);
        feed(LO);
        feed(LO);
        check("R11 pre", int'(gain_ind_dly), 15);
        rst_n = 1'b0;
        step();
        check("R11 ind cleared", int'(gain_ind), 0);
        check("R11 dly cleared", int'(gain_ind_dly), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            feed(LO);
            check("R11 stays clear", int'({gain_ind, gain_ind_dly}), 0);
        end

        report();
    end

endmodule